// File: doc/BRIEF.md
# Saturating Q15 Fractional Multiply-Accumulate

This block is the arithmetic core of a packed-halfword multiply-accumulate operation. Two 32-bit source words each carry two signed Q15 halfwords. A select input picks either the upper pair or the lower pair. The chosen halfwords are multiplied as signed values and doubled into a Q31 product. The one product that cannot be represented, minus one times minus one, is clamped to the largest positive Q31 value.

The product is added to the low 32 bits of a 64-bit accumulator value. That sum is clamped to the signed 32-bit range, and the clamped result is sign-extended into a fresh 64-bit accumulator. A 4-bit vector asks the surrounding logic to set the overflow flag of the accumulator that was named whenever either clamp fired. Bits in this vector are only ever raised; clearing the flags belongs to the surrounding logic.

The datapath is combinational. A parameter adds an output register, which loads only on cycles where the valid strobe is high.

Top module: `q15_mac_sat`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid operation, `acc_out` is zero, `ovf_set` is zero and `out_valid` is low.
- R2: The product is the signed two's-complement product of the two selected halfwords, shifted left by one bit into Q31. Example: 0xFF06 and 0xCB00 added onto a low word of 0x0000B4CB give 0x006838CB.
- R3: When both selected halfwords are 0x8000, the product is forced to 0x7FFFFFFF and the overflow request for the named accumulator is raised, even when the following addition does not clamp.
- R4: With `sel_hi` = 1 the halfwords are bits 31:16 of both sources. With `sel_hi` = 0 they are bits 15:0.
- R5: If the 33-bit signed sum of the accumulator low word and the product overflows in the positive direction (bit 32 = 0, bit 31 = 1), the result is 0x7FFFFFFF and the overflow request is raised.
- R6: If the sum overflows in the negative direction (bit 32 = 1, bit 31 = 0), the result is 0x80000000 and the overflow request is raised.
- R7: The 32-bit result is sign-extended to 64 bits. `acc_out[63:32]` is 0xFFFFFFFF when the result is negative and zero otherwise.
- R8: Bits 63:32 of `acc_in` have no effect on any output.
- R9: `ovf_set` bit i is 1 only when `acc_idx` = i and a clamp from R3, R5 or R6 fired. With no clamp, `ovf_set` is zero.
- R10: With the output register present, which is the default, results appear one cycle after a cycle with `in_valid` high. `out_valid` follows `in_valid` one cycle later, and `acc_out` and `ovf_set` hold their values on cycles where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe; loads the output register |
| sel_hi | input | 1 | 1 selects the upper halfwords, 0 the lower halfwords |
| src_a | input | 32 | First packed Q15 source word |
| src_b | input | 32 | Second packed Q15 source word |
| acc_in | input | 64 | Incoming accumulator value; only bits 31:0 are used |
| acc_idx | input | 2 | Number of the accumulator being updated |
| acc_out | output | 64 | New accumulator value, sign-extended |
| ovf_set | output | 4 | One-hot request to set an accumulator overflow flag |
| out_valid | output | 1 | Marks `acc_out` and `ovf_set` as fresh |

## Verification
The assertions assume that `acc_idx` is always known and below the accumulator count, and that `sel_hi` and the sources are stable around each clock edge. The stimulus changes inputs only on falling edges and uses only indices 0 to 3. The clamp assertions also rely on `in_valid` being sampled on the same edge as the operands. For that reason the bench raises the strobe together with its operands and drops it one cycle later, and its hold checks change operands only while the strobe is low.

// File: rtl/q15_mac_pkg.sv
package q15_mac_pkg;

   typedef enum logic {
      HALF_LOW  = 1'b0,
      HALF_HIGH = 1'b1
   } half_pick_e;

   typedef struct packed {
      logic clamp_mul;
      logic clamp_add;
   } clamp_info_t;

endpackage

// File: rtl/q15_half_pick.sv
module q15_half_pick
   import q15_mac_pkg::*;
#(
   parameter int HALF_W = 16,
   localparam int WORD_W = 2 * HALF_W
) (
   input  half_pick_e          pick,
   input  logic [WORD_W-1:0]   word_a,
   input  logic [WORD_W-1:0]   word_b,
   output logic [HALF_W-1:0]   half_a,
   output logic [HALF_W-1:0]   half_b
);

   always_comb begin
      if (pick == HALF_HIGH) begin
         half_a = word_a[WORD_W-1:HALF_W];
         half_b = word_b[WORD_W-1:HALF_W];
      end else begin
         half_a = word_a[HALF_W-1:0];
         half_b = word_b[HALF_W-1:0];
      end
   end

endmodule

// File: rtl/q15_frac_mul.sv
module q15_frac_mul #(
   parameter int HALF_W = 16,
   localparam int WORD_W = 2 * HALF_W
) (
   input  logic [HALF_W-1:0] op_a,
   input  logic [HALF_W-1:0] op_b,
   output logic [WORD_W-1:0] prod,
   output logic              clamped
);

   localparam logic [HALF_W-1:0] MOST_NEG = {1'b1, {(HALF_W-1){1'b0}}};
   localparam logic [WORD_W-1:0] Q_MAX    = {1'b0, {(WORD_W-1){1'b1}}};

   logic signed [WORD_W-1:0] raw;

   always_comb begin
      raw     = $signed(op_a) * $signed(op_b);
      clamped = (op_a == MOST_NEG) && (op_b == MOST_NEG);
      prod    = clamped ? Q_MAX : (raw <<< 1);
   end

endmodule

// File: rtl/q31_sat_add.sv
module q31_sat_add #(
   parameter int WORD_W = 32
) (
   input  logic [WORD_W-1:0] acc_lo,
   input  logic [WORD_W-1:0] addend,
   output logic [WORD_W-1:0] result,
   output logic              clamped
);

   localparam logic [WORD_W-1:0] POS_LIM = {1'b0, {(WORD_W-1){1'b1}}};
   localparam logic [WORD_W-1:0] NEG_LIM = {1'b1, {(WORD_W-1){1'b0}}};

   logic [WORD_W:0] wide_sum;

   always_comb begin
      wide_sum = {acc_lo[WORD_W-1], acc_lo} + {addend[WORD_W-1], addend};
      clamped  = wide_sum[WORD_W] ^ wide_sum[WORD_W-1];
      if (!clamped)
         result = wide_sum[WORD_W-1:0];
      else if (wide_sum[WORD_W])
         result = NEG_LIM;
      else
         result = POS_LIM;
   end

endmodule

// File: rtl/q15_mac_sat.sv
module q15_mac_sat
   import q15_mac_pkg::*;
#(
   parameter int HALF_W  = 16,
   parameter int NUM_ACC = 4,
   parameter bit REG_OUT = 1'b1,
   localparam int WORD_W = 2 * HALF_W,
   localparam int ACC_W  = 2 * WORD_W,
   localparam int IDX_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               sel_hi,
   input  logic [WORD_W-1:0]  src_a,
   input  logic [WORD_W-1:0]  src_b,
   input  logic [ACC_W-1:0]   acc_in,
   input  logic [IDX_W-1:0]   acc_idx,
   output logic [ACC_W-1:0]   acc_out,
   output logic [NUM_ACC-1:0] ovf_set,
   output logic               out_valid
);

   localparam logic [WORD_W-1:0] POS_LIM = {1'b0, {(WORD_W-1){1'b1}}};
   localparam logic [WORD_W-1:0] NEG_LIM = {1'b1, {(WORD_W-1){1'b0}}};
   localparam logic [HALF_W-1:0] MOST_NEG = {1'b1, {(HALF_W-1){1'b0}}};

   if (HALF_W < 2) begin : g_bad_half
      $error("q15_mac_sat: HALF_W must be at least 2");
   end
   if (NUM_ACC < 1 || (1 << IDX_W) < NUM_ACC) begin : g_bad_acc
      $error("q15_mac_sat: NUM_ACC does not fit the index width");
   end

   logic [HALF_W-1:0]  h_a, h_b;
   logic [WORD_W-1:0]  prod_w, sum_w;
   clamp_info_t        clamp_w;
   logic [ACC_W-1:0]   acc_next;
   logic [NUM_ACC-1:0] flag_next;
   logic [WORD_W-1:0]  unused_acc_hi;

   assign unused_acc_hi = acc_in[ACC_W-1:WORD_W];

   q15_half_pick #(.HALF_W(HALF_W)) u_pick (
      .pick   (half_pick_e'(sel_hi)),
      .word_a (src_a),
      .word_b (src_b),
      .half_a (h_a),
      .half_b (h_b)
   );

   q15_frac_mul #(.HALF_W(HALF_W)) u_mul (
      .op_a    (h_a),
      .op_b    (h_b),
      .prod    (prod_w),
      .clamped (clamp_w.clamp_mul)
   );

   q31_sat_add #(.WORD_W(WORD_W)) u_add (
      .acc_lo  (acc_in[WORD_W-1:0]),
      .addend  (prod_w),
      .result  (sum_w),
      .clamped (clamp_w.clamp_add)
   );

   always_comb begin
      acc_next  = {{WORD_W{sum_w[WORD_W-1]}}, sum_w};
      flag_next = '0;
      if (clamp_w.clamp_mul || clamp_w.clamp_add)
         flag_next[acc_idx] = 1'b1;
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            acc_out   <= '0;
            ovf_set   <= '0;
            out_valid <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               acc_out <= acc_next;
               ovf_set <= flag_next;
            end
         end
      end

      // R3: the doubled minus-one-squared product always raises the flag
      a_r3_min_sq_flag: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && h_a == MOST_NEG && h_b == MOST_NEG) |=> ovf_set[$past(acc_idx)]);

      // R5/R6: a clamped addition lands exactly on one of the limits
      a_r5_clamp_limit: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && clamp_w.clamp_add) |=>
            (acc_out[WORD_W-1:0] == POS_LIM || acc_out[WORD_W-1:0] == NEG_LIM));

      // R6: a negative accumulator plus a negative product clamps low
      a_r6_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && clamp_w.clamp_add && acc_in[WORD_W-1] && prod_w[WORD_W-1]) |=>
            (acc_out[WORD_W-1:0] == NEG_LIM));

      // R7: the upper word is a copy of the result sign
      a_r7_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (acc_out[ACC_W-1:WORD_W] == {WORD_W{acc_out[WORD_W-1]}}));

      // R9: at most one accumulator is flagged at a time
      a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(ovf_set));

      // R10: outputs hold when no operation is presented
      a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> ($stable(acc_out) && $stable(ovf_set) && !out_valid));
   end else begin : g_comb_out
      always_comb begin
         acc_out   = acc_next;
         ovf_set   = flag_next;
         out_valid = in_valid;
      end
   end

endmodule

// File: tb/q15_mac_sat_tb.sv
`timescale 1ns/1ps
module q15_mac_sat_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        sel_hi = 1'b0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [63:0] acc_in = '0;
   logic [1:0]  acc_idx = '0;
   logic [63:0] acc_out;
   logic [3:0]  ovf_set;
   logic        out_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   q15_mac_sat dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_hi(sel_hi),
      .src_a(src_a), .src_b(src_b), .acc_in(acc_in), .acc_idx(acc_idx),
      .acc_out(acc_out), .ovf_set(ovf_set), .out_valid(out_valid)
   );

   task automatic check64(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check4(string req, logic [3:0] act, logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // one operation: drive at falling edge, capture on rising, check at next fall
   task automatic run_op(string req, logic sh, logic [31:0] a, logic [31:0] b,
                         logic [63:0] acc, logic [1:0] idx,
                         logic [63:0] exp_acc, logic [3:0] exp_flag);
      @(negedge clk);
      in_valid = 1'b1; sel_hi = sh; src_a = a; src_b = b; acc_in = acc; acc_idx = idx;
      @(negedge clk);
      in_valid = 1'b0;
      check64(req, acc_out, exp_acc);
      check4(req, ovf_set, exp_flag);
      check64({req, " valid"}, {63'd0, out_valid}, 64'd1);
   endtask

   task automatic t_reset;
      check64("R1 acc", acc_out, 64'd0);
      check4("R1 flag", ovf_set, 4'd0);
      check64("R1 valid", {63'd0, out_valid}, 64'd0);
   endtask

   task automatic t_signed_left;   // R2 R4
      run_op("R2 left example", 1'b1, 32'hFF06_0000, 32'hCB00_0000,
             64'h0000_0000_0000_B4CB, 2'd1, 64'h0000_0000_0068_38CB, 4'b0000);
   endtask

   task automatic t_right_pick;    // R4
      run_op("R4 right halves", 1'b0, 32'hAAAA_0002, 32'h5555_0003,
             64'd0, 2'd0, 64'h0000_0000_0000_000C, 4'b0000);
      run_op("R4 left halves", 1'b1, 32'h0002_AAAA, 32'h0003_5555,
             64'd0, 2'd0, 64'h0000_0000_0000_000C, 4'b0000);
   endtask

   task automatic t_min_sq;        // R3 R5
      run_op("R3 R5 min sq sat", 1'b0, 32'h0000_8000, 32'h0000_8000,
             64'h0000_0000_0000_B4CB, 2'd1, 64'h0000_0000_7FFF_FFFF, 4'b0010);
      run_op("R3 min sq no add clamp", 1'b1, 32'h8000_0000, 32'h8000_0000,
             64'h0000_0000_FFFF_FFFF, 2'd2, 64'h0000_0000_7FFF_FFFE, 4'b0100);
   endtask

   task automatic t_neg_sat;       // R6 R9
      run_op("R6 R9 neg clamp", 1'b0, 32'h0000_FFFF, 32'h0000_0001,
             64'h0000_0000_8000_0000, 2'd3, 64'hFFFF_FFFF_8000_0000, 4'b1000);
   endtask

   task automatic t_pos_add_sat;   // R5
      run_op("R5 pos clamp", 1'b1, 32'h4000_0000, 32'h4000_0000,
             64'h0000_0000_7000_0000, 2'd0, 64'h0000_0000_7FFF_FFFF, 4'b0001);
   endtask

   task automatic t_sign_ext;      // R7 R2
      run_op("R7 negative product", 1'b1, 32'h4000_0000, 32'hC000_0000,
             64'd0, 2'd0, 64'hFFFF_FFFF_E000_0000, 4'b0000);
   endtask

   task automatic t_high_ignored;  // R8
      run_op("R8 high word ignored", 1'b0, 32'h0000_0001, 32'h0000_0001,
             64'h1234_5678_0000_0000, 2'd2, 64'h0000_0000_0000_0002, 4'b0000);
   endtask

   task automatic t_hold;          // R10
      run_op("R10 load", 1'b0, 32'h0000_8000, 32'h0000_8000,
             64'd0, 2'd3, 64'h0000_0000_7FFF_FFFF, 4'b1000);
      @(negedge clk);
      sel_hi = 1'b1; src_a = 32'h0001_0000; src_b = 32'h0001_0000;
      acc_in = 64'd5; acc_idx = 2'd0;
      @(negedge clk);
      @(negedge clk);
      check64("R10 hold acc", acc_out, 64'h0000_0000_7FFF_FFFF);
      check4("R10 hold flag", ovf_set, 4'b1000);
      check64("R10 valid low", {63'd0, out_valid}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_signed_left();
      t_right_pick();
      t_min_sq();
      t_neg_sat();
      t_pos_add_sat();
      t_sign_ext();
      t_high_ignored();
      t_hold();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule